// File: doc/BRIEF.md
# Linked Descriptor Walker for a DMA Channel

This block follows a chain of transfer descriptors held in memory and hands each one to a data mover. A start pulse gives it the address of the first descriptor. It reads the descriptor words it needs over a request/response memory port. It checks that the descriptor describes a legal transfer, then offers the decoded fields to the mover. It waits for the mover to report completion before it moves on to the next link. A chain ends when the link word has its lowest bit set.

Both memory channels and the transfer offer use valid/ready. A request or an offer, once raised, stays raised with its payload unchanged until the receiver accepts it. The receiver may hold ready low for as long as it likes. Only one read is outstanding at a time. The response side is accepted only while the walker waits for data. Completion and error from the mover are plain single-cycle pulses, and so are start and end of chain.

If a descriptor is illegal, or the mover reports an error, the walker goes idle and records a fault code. It keeps the pointer of the offending descriptor and its byte count, so the cause can be inspected afterwards.

Top module: `dma_chain_walker`

## Requirements
- R1: `start` is taken only while `busy` is low. On acceptance, `cur_ptr` becomes `start_ptr` with bits 3:0 cleared, `remaining_count` becomes 0, `fault_code` becomes 0 and `busy` rises. A `start` pulse while busy has no effect on the run in progress.
- R2: For each descriptor the walker issues reads at `cur_ptr`+0, +4, +8, +16 and +24, in that order, with one read outstanding. `rd_req_valid` and `rd_req_addr` hold until `rd_req_ready`.
- R3: The word at +0 is the control word, +4 the byte count, +8 the local address, +16 the remote address and +24 the link word. These appear unchanged on `xfer_ctrl`, `xfer_count`, `xfer_local` and `xfer_remote`.
- R4: `xfer_valid` stays high with stable fields until `xfer_ready` is seen. Exactly one offer is made per legal descriptor.
- R5: After `mover_done`, `remaining_count` becomes 0. If bit 0 of the link word is 1, `chain_end` pulses and `busy` falls. Otherwise the walker fetches from the link word with bits 3:0 cleared.
- R6: A byte count of 0, or of 2^24 or more, is illegal. The walker then makes no offer, sets `fault_code` to 1 and goes idle. A count of 2^24-1 is legal.
- R7: A descriptor whose local and remote addresses differ in bits 2:0 is illegal (fault code 1, no offer).
- R8: Control bits 18:16 select the address space. Codes 0, 1, 2, 6 and 7 are legal. Codes 3, 4 and 5 are illegal (fault code 1, no offer).
- R9: `mover_error` while waiting sets `fault_code` to 2 and ends the run. `cur_ptr` keeps the failing descriptor's address and `remaining_count` keeps its byte count. After a fault 1, `remaining_count` holds the illegal descriptor's byte count.
- R10: `xfer_to_remote` equals control bit 31. `xfer_beat_bytes` is 1, 2, 4 or 8 for control bits 23:22 = 00, 01, 10 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin walking a chain |
| start_ptr | input | 32 | Address of the first descriptor |
| busy | output | 1 | A chain is being walked |
| chain_end | output | 1 | One-cycle pulse when the last descriptor completes |
| fault_code | output | 2 | 0 none, 1 illegal descriptor, 2 mover error |
| cur_ptr | output | 32 | Address of the current descriptor |
| remaining_count | output | 32 | Byte count of the current descriptor, 0 once done |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Byte address of the word to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Walker accepts read data |
| rd_rsp_data | input | 32 | Read data |
| xfer_valid | output | 1 | Transfer offer valid |
| xfer_ready | input | 1 | Mover accepts the offer |
| xfer_ctrl | output | 32 | Control word |
| xfer_count | output | 32 | Byte count |
| xfer_local | output | 32 | Local-side address |
| xfer_remote | output | 32 | Remote-side address |
| xfer_to_remote | output | 1 | Direction: 1 local to remote |
| xfer_beat_bytes | output | 4 | Remote data width in bytes |
| mover_done | input | 1 | Mover finished the current transfer |
| mover_error | input | 1 | Mover failed the current transfer |

## Verification
The bench builds the block with its defaults: a 24-bit count limit and 16-byte descriptor alignment. With these values the count boundary can be reached directly, using 2^24-1 and 2^24 as the two sides of the legal limit. The 16-byte alignment means a random value in the low four bits of every start and link pointer exercises the masking. A 1 KiB memory model holds up to 32 descriptor slots, so chains of up to six links are placed out of order. Each test adds an illegal descriptor or a mover failure at a chosen position.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  localparam int WORD_W  = 32;
  localparam int NFETCH  = 5;   // words actually read per descriptor
  localparam int FIDX_W  = 3;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_DESC  = 2'd1,
    FLT_MOVER = 2'd2
  } fault_e;

  typedef struct packed {
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] count;
    logic [WORD_W-1:0] loc_addr;
    logic [WORD_W-1:0] rem_addr;
    logic [WORD_W-1:0] link;
  } desc_t;

  // byte offset inside a descriptor for each fetched word
  function automatic logic [4:0] word_offset(input logic [FIDX_W-1:0] i);
    case (i)
      3'd0:    return 5'd0;
      3'd1:    return 5'd4;
      3'd2:    return 5'd8;
      3'd3:    return 5'd16;
      default: return 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/dcw_fetch.sv
module dcw_fetch
  import dcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] base,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [WORD_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output desc_t             desc,
  output logic              fetch_done
);
  logic              active;
  logic              waiting_rsp;
  logic [FIDX_W-1:0] idx;
  logic              rsp_fire;

  assign rd_req_valid = active && !waiting_rsp;
  assign rd_rsp_ready = active && waiting_rsp;
  assign rd_req_addr  = base + WORD_W'(word_offset(idx));
  assign rsp_fire     = rd_rsp_ready && rd_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      waiting_rsp <= 1'b0;
      idx         <= '0;
      fetch_done  <= 1'b0;
    end else begin
      fetch_done <= 1'b0;
      if (go) begin
        active      <= 1'b1;
        waiting_rsp <= 1'b0;
        idx         <= '0;
      end else if (rd_req_valid && rd_req_ready) begin
        waiting_rsp <= 1'b1;
      end else if (rsp_fire) begin
        waiting_rsp <= 1'b0;
        if (idx == FIDX_W'(NFETCH - 1)) begin
          active     <= 1'b0;
          fetch_done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc <= '0;
    end else if (rsp_fire) begin
      case (idx)
        3'd0:    desc.ctrl     <= rd_rsp_data;
        3'd1:    desc.count    <= rd_rsp_data;
        3'd2:    desc.loc_addr <= rd_rsp_data;
        3'd3:    desc.rem_addr <= rd_rsp_data;
        default: desc.link     <= rd_rsp_data;
      endcase
    end
  end

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready |-> !rd_req_valid);
endmodule

// File: rtl/dcw_check.sv
module dcw_check
  import dcw_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic [WORD_W-1:0] count,
  input  logic [2:0]        space,
  input  logic [1:0]        width_code,
  input  logic [2:0]        loc_low,
  input  logic [2:0]        rem_low,
  output logic              legal,
  output logic [3:0]        beat_bytes
);
  logic count_ok, space_ok, align_ok;

  assign count_ok = (count != '0) && ((count >> CNT_W) == '0);
  assign align_ok = (loc_low == rem_low);

  always_comb begin
    case (space)
      3'd0, 3'd1, 3'd2, 3'd6, 3'd7: space_ok = 1'b1;
      default:                      space_ok = 1'b0;
    endcase
  end

  assign legal      = count_ok && space_ok && align_ok;
  assign beat_bytes = 4'd1 << width_code;
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
  import dcw_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int ALIGN_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_ptr,
  output logic        busy,
  output logic        chain_end,
  output logic [1:0]  fault_code,
  output logic [31:0] cur_ptr,
  output logic [31:0] remaining_count,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  output logic        rd_rsp_ready,
  input  logic [31:0] rd_rsp_data,
  output logic        xfer_valid,
  input  logic        xfer_ready,
  output logic [31:0] xfer_ctrl,
  output logic [31:0] xfer_count,
  output logic [31:0] xfer_local,
  output logic [31:0] xfer_remote,
  output logic        xfer_to_remote,
  output logic [3:0]  xfer_beat_bytes,
  input  logic        mover_done,
  input  logic        mover_error
);
  localparam logic [WORD_W-1:0] ALIGN_MASK = WORD_W'((1 << ALIGN_BITS) - 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT} state_e;

  state_e            state;
  fault_e            fault_q;
  desc_t             desc;
  logic              fetch_go, fetch_done, legal;
  logic              last_link, follow;

  assign last_link = desc.link[0];
  assign follow    = (state == S_WAIT) && mover_done && !mover_error && !last_link;
  assign fetch_go  = ((state == S_IDLE) && start) || follow;

  dcw_fetch u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (fetch_go),
    .base         (cur_ptr),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_ready (rd_rsp_ready),
    .rd_rsp_data  (rd_rsp_data),
    .desc         (desc),
    .fetch_done   (fetch_done)
  );

  dcw_check #(.CNT_W(CNT_W)) u_check (
    .count      (desc.count),
    .space      (desc.ctrl[18:16]),
    .width_code (desc.ctrl[23:22]),
    .loc_low    (desc.loc_addr[2:0]),
    .rem_low    (desc.rem_addr[2:0]),
    .legal      (legal),
    .beat_bytes (xfer_beat_bytes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      fault_q         <= FLT_NONE;
      cur_ptr         <= '0;
      remaining_count <= '0;
      chain_end       <= 1'b0;
    end else begin
      chain_end <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cur_ptr         <= start_ptr & ~ALIGN_MASK;
          remaining_count <= '0;
          fault_q         <= FLT_NONE;
          state           <= S_FETCH;
        end
        S_FETCH: if (fetch_done) begin
          remaining_count <= desc.count;
          if (legal) begin
            state <= S_ISSUE;
          end else begin
            fault_q <= FLT_DESC;
            state   <= S_IDLE;
          end
        end
        S_ISSUE: if (xfer_ready) state <= S_WAIT;
        S_WAIT: begin
          if (mover_error) begin
            fault_q <= FLT_MOVER;
            state   <= S_IDLE;
          end else if (mover_done) begin
            remaining_count <= '0;
            if (last_link) begin
              chain_end <= 1'b1;
              state     <= S_IDLE;
            end else begin
              cur_ptr <= desc.link & ~ALIGN_MASK;
              state   <= S_FETCH;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy           = (state != S_IDLE);
  assign fault_code     = fault_q;
  assign xfer_valid     = (state == S_ISSUE);
  assign xfer_ctrl      = desc.ctrl;
  assign xfer_count     = desc.count;
  assign xfer_local     = desc.loc_addr;
  assign xfer_remote    = desc.rem_addr;
  assign xfer_to_remote = desc.ctrl[31];

  a_r1_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (remaining_count == 32'd0 && fault_code == 2'd0));

  a_r4_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_count)
                                     && $stable(xfer_local) && $stable(xfer_remote)));

  a_r6_issue_count: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_count != 32'd0 && (xfer_count >> CNT_W) == 32'd0));

  a_r7_issue_align: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_local[2:0] == xfer_remote[2:0]));

  a_r5_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    chain_end |-> !busy);
endmodule

// File: tb/sim_dma_chain_walker.sv
module sim_dma_chain_walker;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start;
  logic [31:0] start_ptr;
  logic        busy, chain_end;
  logic [1:0]  fault_code;
  logic [31:0] cur_ptr, remaining_count;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [31:0] rd_req_addr, rd_rsp_data;
  logic        xfer_valid, xfer_ready, xfer_to_remote, mover_done, mover_error;
  logic [31:0] xfer_ctrl, xfer_count, xfer_local, xfer_remote;
  logic [3:0]  xfer_beat_bytes;

  dma_chain_walker u0 (.*);

  logic [31:0] mem [0:255];
  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expectations
  logic [31:0] e_addr [0:127];
  logic [31:0] e_ctrl [0:15], e_cnt [0:15], e_loc [0:15], e_rem [0:15];
  int          e_addr_n, e_x_n, got_req, got_x, cur_err_at;
  logic [1:0]  e_fault;
  logic [31:0] e_ptr, e_rcnt;
  bit          e_end, hold_bad;
  int          sl [0:15];

  function automatic bit desc_legal(input logic [31:0] c, n, l, r);
    logic [2:0] sp = c[18:16];
    return (n != 0) && (n < 32'h0100_0000) && (l[2:0] == r[2:0]) &&
           (sp == 0 || sp == 1 || sp == 2 || sp == 6 || sp == 7);
  endfunction

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[8'(a >> 2)];
  endfunction

  task automatic plan(input logic [31:0] sp, input int err_at);
    logic [31:0] p, c, n, l, r, k;
    p = sp & ~32'hF; e_addr_n = 0; e_x_n = 0; e_fault = 0; e_end = 0;
    for (int d = 0; d < 16; d++) begin
      e_addr[e_addr_n] = p;      e_addr[e_addr_n+1] = p + 4;
      e_addr[e_addr_n+2] = p + 8; e_addr[e_addr_n+3] = p + 16;
      e_addr[e_addr_n+4] = p + 24; e_addr_n += 5;
      c = rd(p); n = rd(p + 4); l = rd(p + 8); r = rd(p + 16); k = rd(p + 24);
      e_ptr = p; e_rcnt = n;
      if (!desc_legal(c, n, l, r)) begin e_fault = 1; return; end
      e_ctrl[e_x_n] = c; e_cnt[e_x_n] = n; e_loc[e_x_n] = l; e_rem[e_x_n] = r;
      e_x_n++;
      if (d == err_at) begin e_fault = 2; return; end
      e_rcnt = 0;
      if (k[0]) begin e_end = 1; return; end
      p = k & ~32'hF;
    end
  endtask

  function automatic logic [2:0] legal_space(input int i);
    case (i % 5)
      0: return 3'd0; 1: return 3'd1; 2: return 3'd2; 3: return 3'd6; default: return 3'd7;
    endcase
  endfunction

  task automatic put(input int slot, input logic [31:0] c, n, l, r, k);
    logic [7:0] b = 8'(slot * 8);
    mem[b] = c; mem[b+1] = n; mem[b+2] = l; mem[b+3] = $urandom;
    mem[b+4] = r; mem[b+5] = $urandom; mem[b+6] = k; mem[b+7] = $urandom;
  endtask

  task automatic make_chain(input int len, output logic [31:0] head);
    int s0 = $urandom % 32;
    logic [31:0] c, l, r, k;
    for (int i = 0; i < len; i++) sl[i] = (s0 + i * 3) % 32;
    for (int i = 0; i < len; i++) begin
      c = $urandom; c[18:16] = legal_space($urandom);
      l = $urandom; r = $urandom; r[2:0] = l[2:0];
      k = (i == len - 1) ? 32'h1 : 32'(sl[i+1] * 32);
      k[3:1] = 3'($urandom);
      put(sl[i], c, 32'd1 + ($urandom % 32'h00FF_FFFF), l, r, k);
    end
    head = 32'(sl[0] * 32) | ($urandom & 32'hF);
  endtask

  // monitor
  logic        req_fire, rsp_fire, xfer_fire, stall_prev;
  logic [31:0] req_addr_s, x_ctrl_s, x_cnt_s, x_loc_s, x_rem_s, stall_cnt;
  logic        x_dir_s;
  logic [3:0]  x_beat_s;
  always @(posedge clk) begin
    req_fire   <= rd_req_valid && rd_req_ready;
    req_addr_s <= rd_req_addr;
    rsp_fire   <= rd_rsp_valid && rd_rsp_ready;
    xfer_fire  <= xfer_valid && xfer_ready;
    x_ctrl_s <= xfer_ctrl; x_cnt_s <= xfer_count; x_loc_s <= xfer_local;
    x_rem_s  <= xfer_remote; x_dir_s <= xfer_to_remote; x_beat_s <= xfer_beat_bytes;
    if (stall_prev && !(xfer_valid && xfer_count == stall_cnt)) hold_bad <= 1'b1;
    stall_prev <= xfer_valid && !xfer_ready;
    stall_cnt  <= xfer_count;
  end

  // memory model
  initial begin
    bit pend = 0; int lat = 0; logic [31:0] dat = 0;
    rd_req_ready = 0; rd_rsp_valid = 0; rd_rsp_data = 0;
    forever begin
      @(negedge clk);
      if (rsp_fire) rd_rsp_valid = 0;
      if (req_fire) begin
        if (got_req < e_addr_n)
          check(req_addr_s == e_addr[got_req], "R2 fetch address (R1 mask)", req_addr_s, e_addr[got_req]);
        else check(0, "R2 extra fetch", req_addr_s, 32'hFFFF_FFFF);
        got_req++;
        pend = 1; lat = $urandom % 3; dat = rd(req_addr_s);
      end
      if (pend && !rd_rsp_valid) begin
        if (lat == 0) begin rd_rsp_valid = 1; rd_rsp_data = dat; pend = 0; end
        else lat--;
      end
      rd_req_ready = !pend && !rd_rsp_valid && ($urandom % 4 != 0);
    end
  end

  // mover model
  initial begin
    bit wt = 0, er = 0; int lat = 0;
    xfer_ready = 0; mover_done = 0; mover_error = 0;
    forever begin
      @(negedge clk);
      mover_done = 0; mover_error = 0;
      if (xfer_fire) begin
        if (got_x < e_x_n) begin
          check(x_ctrl_s == e_ctrl[got_x], "R3 control word", x_ctrl_s, e_ctrl[got_x]);
          check(x_cnt_s == e_cnt[got_x], "R3 byte count", x_cnt_s, e_cnt[got_x]);
          check(x_loc_s == e_loc[got_x], "R3 local address", x_loc_s, e_loc[got_x]);
          check(x_rem_s == e_rem[got_x], "R3 remote address", x_rem_s, e_rem[got_x]);
          check(x_dir_s == e_ctrl[got_x][31], "R10 direction", 32'(x_dir_s), 32'(e_ctrl[got_x][31]));
          check(x_beat_s == (4'd1 << e_ctrl[got_x][23:22]), "R10 beat bytes",
                32'(x_beat_s), 32'(4'd1 << e_ctrl[got_x][23:22]));
        end else check(0, "R4 unexpected offer", x_cnt_s, 32'd0);
        er = (got_x == cur_err_at); got_x++;
        wt = 1; lat = $urandom % 4; xfer_ready = 0;
      end else if (wt) begin
        if (lat == 0) begin
          if (er) mover_error = 1; else mover_done = 1;
          wt = 0;
        end else lat--;
      end else xfer_ready = ($urandom % 3 != 0);
    end
  end

  task automatic run(input logic [31:0] sp, input int err_at, input bit poke, input string tag);
    plan(sp, err_at);
    got_req = 0; got_x = 0; cur_err_at = err_at; hold_bad = 0;
    @(negedge clk); start = 1; start_ptr = sp;
    @(negedge clk); start = 0;
    check(busy == 1, "R1 busy after start", 32'(busy), 32'd1);
    check(remaining_count == 0, "R1 count cleared", remaining_count, 32'd0);
    check(fault_code == 0, "R1 fault cleared", 32'(fault_code), 32'd0);
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1; start_ptr = 32'h0000_0040;
      @(negedge clk); start = 0;
    end
    do @(negedge clk); while (busy);
    check(fault_code == e_fault, {tag, " fault code"}, 32'(fault_code), 32'(e_fault));
    check(cur_ptr == e_ptr, {tag, " pointer"}, cur_ptr, e_ptr);
    check(remaining_count == e_rcnt, {tag, " remaining"}, remaining_count, e_rcnt);
    check(chain_end == e_end, "R5 chain end pulse", 32'(chain_end), 32'(e_end));
    check(got_x == e_x_n, {tag, " offers"}, 32'(got_x), 32'(e_x_n));
    check(got_req == e_addr_n, "R2 read count", 32'(got_req), 32'(e_addr_n));
    check(!hold_bad, "R4 offer hold", 32'(hold_bad), 32'd0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] h;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    stall_prev = 0; hold_bad = 0; e_addr_n = 0; e_x_n = 0; got_req = 0; got_x = 0;
    cur_err_at = -1; rst_n = 0; start = 0; start_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R1 reset idle", 32'(busy), 32'd0);
    check(rd_req_valid == 0, "R2 reset no read", 32'(rd_req_valid), 32'd0);
    check(xfer_valid == 0, "R4 reset no offer", 32'(xfer_valid), 32'd0);
    check(fault_code == 0 && remaining_count == 0, "R9 reset status",
          {remaining_count[29:0], fault_code}, 32'd0);

    // single descriptor, start pointer with low bits set
    make_chain(1, h); run(h | 32'h7, -1, 0, "R5");

    // random chains
    for (int t = 0; t < 20; t++) begin
      make_chain(1 + $urandom % 6, h); run(h, -1, 0, "R5");
    end

    // R6: zero count in second descriptor
    make_chain(3, h); mem[8'(sl[1] * 8 + 1)] = 0; run(h, -1, 0, "R6");
    // R6: count at the limit
    make_chain(2, h); mem[8'(sl[0] * 8 + 1)] = 32'h0100_0000; run(h, -1, 0, "R6");
    // R6: largest legal count
    make_chain(2, h); mem[8'(sl[1] * 8 + 1)] = 32'h00FF_FFFF; run(h, -1, 0, "R6");
    // R7: low address bits differ in third descriptor
    make_chain(4, h); mem[8'(sl[2] * 8 + 4)] = mem[8'(sl[2] * 8 + 2)] ^ 32'h4; run(h, -1, 0, "R7");
    // R8: illegal space codes, then a legal high code
    for (int s = 3; s <= 5; s++) begin
      make_chain(2, h); mem[8'(sl[1] * 8)][18:16] = 3'(s); run(h, -1, 0, "R8");
    end
    make_chain(2, h); mem[8'(sl[0] * 8)][18:16] = 3'd7; run(h, -1, 0, "R8");
    // R9: mover error mid-chain and at the first descriptor
    make_chain(4, h); run(h, 1, 0, "R9");
    make_chain(3, h); run(h, 0, 0, "R9");
    // R1: start while busy ignored
    make_chain(3, h); run(h, -1, 1, "R1");
    // random mix of failures
    for (int t = 0; t < 8; t++) begin
      make_chain(2 + $urandom % 4, h); run(h, int'($urandom % 5) - 1, 0, "R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule